// File: doc/BRIEF.md
# Thread Block Dispatcher

This block hands the thread blocks of one compute grid, one at a time and in request order, to a set of multiprocessor slots. Every request names the block's thread count, the registers each thread needs and the shared memory the block needs. The dispatcher keeps a ledger for each multiprocessor of its resident blocks, resident warps, allocated registers and allocated shared memory. It places the block at the head of the stream on the first multiprocessor that can hold all four amounts. If no multiprocessor can hold it now, the head waits, so the grid is never reordered. A request that could never fit, even on an empty multiprocessor, is consumed and reported as a launch error. It is not left blocking the stream.

A grid begins with a start pulse that gives its block count. Blocks return their resources through a completion port. That port gives the multiprocessor index and the same three size fields the block was launched with, and the ledger recomputes the warps and registers to return. The done flag rises when every block of the grid has been dispensed and no multiprocessor has a block resident. Dispensed means either placed or rejected.

The control is a four-state machine. WAIT accepts a request. SCAN sizes it and looks for a home. GRANT offers the placement. REJECT signals an impossible block. WAIT goes to SCAN when a request is accepted. SCAN goes to REJECT when the block can never fit. SCAN goes to GRANT when a multiprocessor fits it, and SCAN stays in SCAN while nothing fits. GRANT goes back to WAIT when the consumer takes the placement. REJECT always goes back to WAIT after one cycle.

Top module: `block_dispatch`

## Requirements
- R1: After reset, req_ready, asg_valid, launch_err and grid_done are all low, and the first placement goes to multiprocessor 0.
- R2: A block occupies ceil(threads / 32) warps. It is placed only where resident warps plus its warps stay at or below 32.
- R3: No multiprocessor ever holds more than 8 resident blocks.
- R4: A block uses threads × registers-per-thread register entries. It is placed only where the allocated total stays at or below 16384.
- R5: A block is placed only where allocated shared memory plus its request stays at or below 16384 bytes.
- R6: A request with zero threads, more than 512 threads, more than 16384 bytes of shared memory, or more than 16384 register entries is consumed without a placement. launch_err is high for exactly one cycle, two cycles after the request is accepted.
- R7: The search for a home starts at the multiprocessor after the one that received the previous block and wraps around. The first multiprocessor that fits wins.
- R8: Requests are handled strictly in order. req_ready is high only in WAIT while the grid still has undispensed blocks, and it stays low while the head block waits for room. asg_block is the request's position in the grid, starting at 0.
- R9: A completion returns the block's slot, warps, registers and shared memory to the named multiprocessor. It may land in the same cycle as a placement on that multiprocessor, and both take effect.
- R10: grid_done is high only when all grid_blocks requests have been dispensed, the machine is in WAIT and no multiprocessor has a block resident. A grid of zero blocks is done one cycle after its start.
- R11: While asg_valid is high and asg_ready is low, asg_valid, asg_mp and asg_block hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grid_start | input | 1 | Pulse that arms a new grid |
| grid_blocks | input | BLK_W | Number of blocks in the grid being started |
| req_valid | input | 1 | Block request present |
| req_ready | output | 1 | Dispatcher accepts a request this cycle |
| req_threads | input | THR_W | Threads in the requested block |
| req_regs | input | RPT_W | Registers per thread |
| req_smem | input | SM_W | Shared memory bytes for the block |
| asg_valid | output | 1 | Placement offered |
| asg_ready | input | 1 | Placement consumed |
| asg_mp | output | MP_W | Multiprocessor that received the block |
| asg_block | output | BLK_W | Position of the block in the grid |
| launch_err | output | 1 | One-cycle pulse for an impossible block |
| cpl_valid | input | 1 | A resident block has finished |
| cpl_mp | input | MP_W | Multiprocessor of the finished block |
| cpl_threads | input | THR_W | Thread count of the finished block |
| cpl_regs | input | RPT_W | Registers per thread of the finished block |
| cpl_smem | input | SM_W | Shared memory of the finished block |
| grid_done | output | 1 | Every block dispensed and none resident |

## Verification
A placement decided in SCAN and a completion naming the same multiprocessor can fall in the same cycle. The ledger must then add one block and remove another in a single update. The bench provokes this by filling the multiprocessors until the head request stalls, then streaming completions while further requests keep arriving. Random grids with random consumer stalls add more overlaps. A behavioural model checks every cycle that each later placement decision matches a ledger that applied both the addition and the removal.

// File: rtl/bd_pkg.sv
package bd_pkg;

    typedef enum logic [1:0] {
        S_WAIT   = 2'd0,
        S_SCAN   = 2'd1,
        S_GRANT  = 2'd2,
        S_REJECT = 2'd3
    } disp_state_e;

endpackage

// File: rtl/bd_sizer.sv
// Turns a block's size fields into warp and register-entry demand and flags
// a block that no empty multiprocessor could ever hold.
module bd_sizer #(
    parameter int THR_W       = 10,
    parameter int RPT_W       = 8,
    parameter int SM_W        = 16,
    parameter int WQ_W        = 6,
    parameter int PROD_W      = 18,
    parameter int WARP_SIZE   = 32,
    parameter int MAX_THREADS = 512,
    parameter int REG_BUDGET  = 16384,
    parameter int SMEM_BUDGET = 16384
) (
    input  logic [THR_W-1:0]  thr,
    input  logic [RPT_W-1:0]  rpt,
    input  logic [SM_W-1:0]   smem,
    output logic [WQ_W-1:0]   warps,
    output logic [PROD_W-1:0] regs,
    output logic              fatal
);
    localparam int WS_LOG = $clog2(WARP_SIZE);

    logic [THR_W:0] padded;

    assign padded = {1'b0, thr} + (THR_W+1)'(WARP_SIZE - 1);
    assign warps  = WQ_W'(padded >> WS_LOG);
    assign regs   = PROD_W'(thr) * PROD_W'(rpt);
    assign fatal  = (thr == '0)
                 || (thr  > THR_W'(MAX_THREADS))
                 || (smem > SM_W'(SMEM_BUDGET))
                 || (regs > PROD_W'(REG_BUDGET));
endmodule

// File: rtl/bd_ledger.sv
// Resource ledger of one multiprocessor: occupancy counters plus the fit test
// for the block currently at the head of the stream.
module bd_ledger #(
    parameter int MAX_BLOCKS  = 8,
    parameter int MAX_WARPS   = 32,
    parameter int REG_BUDGET  = 16384,
    parameter int SMEM_BUDGET = 16384,
    parameter int WQ_W        = 6,
    parameter int PROD_W      = 18,
    parameter int SM_W        = 16,
    parameter int SUM_W       = 19,
    parameter int OB_W        = 4,
    parameter int OW_W        = 6,
    parameter int OR_W        = 15,
    parameter int OS_W        = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add,
    input  logic              sub,
    input  logic [WQ_W-1:0]   need_w,
    input  logic [PROD_W-1:0] need_r,
    input  logic [SM_W-1:0]   need_s,
    input  logic [WQ_W-1:0]   rel_w,
    input  logic [PROD_W-1:0] rel_r,
    input  logic [SM_W-1:0]   rel_s,
    output logic              fit,
    output logic              empty,
    output logic [OB_W-1:0]   occ_b,
    output logic [OW_W-1:0]   occ_w,
    output logic [OR_W-1:0]   occ_r,
    output logic [OS_W-1:0]   occ_s
);
    logic [SUM_W-1:0] pro_b, pro_w, pro_r, pro_s;

    assign pro_b = SUM_W'(occ_b) + SUM_W'(1);
    assign pro_w = SUM_W'(occ_w) + SUM_W'(need_w);
    assign pro_r = SUM_W'(occ_r) + SUM_W'(need_r);
    assign pro_s = SUM_W'(occ_s) + SUM_W'(need_s);

    assign fit = (pro_b <= SUM_W'(MAX_BLOCKS))
              && (pro_w <= SUM_W'(MAX_WARPS))
              && (pro_r <= SUM_W'(REG_BUDGET))
              && (pro_s <= SUM_W'(SMEM_BUDGET));

    assign empty = (occ_b == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_b <= '0;
            occ_w <= '0;
            occ_r <= '0;
            occ_s <= '0;
        end else if (add || sub) begin
            occ_b <= OB_W'(SUM_W'(occ_b) + (add ? SUM_W'(1) : '0)
                                         - (sub ? SUM_W'(1) : '0));
            occ_w <= OW_W'(SUM_W'(occ_w) + (add ? SUM_W'(need_w) : '0)
                                         - (sub ? SUM_W'(rel_w) : '0));
            occ_r <= OR_W'(SUM_W'(occ_r) + (add ? SUM_W'(need_r) : '0)
                                         - (sub ? SUM_W'(rel_r) : '0));
            occ_s <= OS_W'(SUM_W'(occ_s) + (add ? SUM_W'(need_s) : '0)
                                         - (sub ? SUM_W'(rel_s) : '0));
        end
    end
endmodule

// File: rtl/bd_rr_pick.sv
// Rotating-priority pick: the search begins one past the last winner.
module bd_rr_pick #(
    parameter int NUM_MP = 4,
    parameter int MP_W   = 2
) (
    input  logic [NUM_MP-1:0] fit,
    input  logic [MP_W-1:0]   last,
    output logic              found,
    output logic [MP_W-1:0]   pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < NUM_MP; k++) begin
            int idx;
            idx = (int'(last) + 1 + k) % NUM_MP;
            if (!found && fit[idx]) begin
                found = 1'b1;
                pick  = MP_W'(idx);
            end
        end
    end
endmodule

// File: rtl/block_dispatch.sv
module block_dispatch #(
    parameter int NUM_MP      = 4,
    parameter int MAX_BLOCKS  = 8,
    parameter int MAX_WARPS   = 32,
    parameter int WARP_SIZE   = 32,
    parameter int MAX_THREADS = 512,
    parameter int REG_BUDGET  = 16384,
    parameter int SMEM_BUDGET = 16384,
    parameter int THR_W       = 10,
    parameter int RPT_W       = 8,
    parameter int SM_W        = 16,
    parameter int BLK_W       = 16,
    parameter int MP_W        = (NUM_MP > 1) ? $clog2(NUM_MP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grid_start,
    input  logic [BLK_W-1:0] grid_blocks,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [THR_W-1:0] req_threads,
    input  logic [RPT_W-1:0] req_regs,
    input  logic [SM_W-1:0]  req_smem,
    output logic             asg_valid,
    input  logic             asg_ready,
    output logic [MP_W-1:0]  asg_mp,
    output logic [BLK_W-1:0] asg_block,
    output logic             launch_err,
    input  logic             cpl_valid,
    input  logic [MP_W-1:0]  cpl_mp,
    input  logic [THR_W-1:0] cpl_threads,
    input  logic [RPT_W-1:0] cpl_regs,
    input  logic [SM_W-1:0]  cpl_smem,
    output logic             grid_done
);
    import bd_pkg::*;

    localparam int WQ_W   = THR_W - $clog2(WARP_SIZE) + 1;
    localparam int PROD_W = THR_W + RPT_W;
    localparam int SUM_W  = ((PROD_W > SM_W) ? PROD_W : SM_W) + 1;
    localparam int OB_W   = $clog2(MAX_BLOCKS + 1);
    localparam int OW_W   = $clog2(MAX_WARPS + 1);
    localparam int OR_W   = $clog2(REG_BUDGET + 1);
    localparam int OS_W   = $clog2(SMEM_BUDGET + 1);

    disp_state_e state_q, state_d;

    logic             armed_q;
    logic [BLK_W-1:0] target_q, issued_q;
    logic [THR_W-1:0] rq_thr_q;
    logic [RPT_W-1:0] rq_rpt_q;
    logic [SM_W-1:0]  rq_smem_q;
    logic [BLK_W-1:0] blk_q;
    logic [MP_W-1:0]  mp_q, last_q;

    logic [WQ_W-1:0]   need_w, rel_w;
    logic [PROD_W-1:0] need_r, rel_r;
    logic              rq_fatal, cpl_fatal_unused;

    logic [NUM_MP-1:0] fit_v, empty_v;
    logic              found;
    logic [MP_W-1:0]   pick;
    logic              accept, commit;

    logic [NUM_MP-1:0][OB_W-1:0] occ_b;
    logic [NUM_MP-1:0][OW_W-1:0] occ_w;
    logic [NUM_MP-1:0][OR_W-1:0] occ_r;
    logic [NUM_MP-1:0][OS_W-1:0] occ_s;

    // Demand of the held request.
    bd_sizer #(
        .THR_W(THR_W), .RPT_W(RPT_W), .SM_W(SM_W), .WQ_W(WQ_W), .PROD_W(PROD_W),
        .WARP_SIZE(WARP_SIZE), .MAX_THREADS(MAX_THREADS),
        .REG_BUDGET(REG_BUDGET), .SMEM_BUDGET(SMEM_BUDGET)
    ) u_req_size (
        .thr(rq_thr_q), .rpt(rq_rpt_q), .smem(rq_smem_q),
        .warps(need_w), .regs(need_r), .fatal(rq_fatal)
    );

    // Amounts handed back by a finishing block.
    bd_sizer #(
        .THR_W(THR_W), .RPT_W(RPT_W), .SM_W(SM_W), .WQ_W(WQ_W), .PROD_W(PROD_W),
        .WARP_SIZE(WARP_SIZE), .MAX_THREADS(MAX_THREADS),
        .REG_BUDGET(REG_BUDGET), .SMEM_BUDGET(SMEM_BUDGET)
    ) u_cpl_size (
        .thr(cpl_threads), .rpt(cpl_regs), .smem(cpl_smem),
        .warps(rel_w), .regs(rel_r), .fatal(cpl_fatal_unused)
    );

    generate
        for (genvar g = 0; g < NUM_MP; g++) begin : g_mp
            bd_ledger #(
                .MAX_BLOCKS(MAX_BLOCKS), .MAX_WARPS(MAX_WARPS),
                .REG_BUDGET(REG_BUDGET), .SMEM_BUDGET(SMEM_BUDGET),
                .WQ_W(WQ_W), .PROD_W(PROD_W), .SM_W(SM_W), .SUM_W(SUM_W),
                .OB_W(OB_W), .OW_W(OW_W), .OR_W(OR_W), .OS_W(OS_W)
            ) u_ledger (
                .clk(clk), .rst_n(rst_n),
                .add(commit && (pick == MP_W'(g))),
                .sub(cpl_valid && (cpl_mp == MP_W'(g))),
                .need_w(need_w), .need_r(need_r), .need_s(rq_smem_q),
                .rel_w(rel_w), .rel_r(rel_r), .rel_s(cpl_smem),
                .fit(fit_v[g]), .empty(empty_v[g]),
                .occ_b(occ_b[g]), .occ_w(occ_w[g]),
                .occ_r(occ_r[g]), .occ_s(occ_s[g])
            );
        end
    endgenerate

    bd_rr_pick #(.NUM_MP(NUM_MP), .MP_W(MP_W)) u_pick (
        .fit(fit_v), .last(last_q), .found(found), .pick(pick)
    );

    assign accept = req_ready && req_valid;
    assign commit = (state_q == S_SCAN) && !rq_fatal && found;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_WAIT;
        else        state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT:   if (accept) state_d = S_SCAN;
            S_SCAN: begin
                if (rq_fatal)   state_d = S_REJECT;
                else if (found) state_d = S_GRANT;
            end
            S_GRANT:  if (asg_ready) state_d = S_WAIT;
            S_REJECT: state_d = S_WAIT;
            default:  state_d = S_WAIT;
        endcase
    end

    // Outputs.
    always_comb begin
        req_ready  = (state_q == S_WAIT) && armed_q && (issued_q < target_q);
        asg_valid  = (state_q == S_GRANT);
        launch_err = (state_q == S_REJECT);
        grid_done  = armed_q && (issued_q == target_q)
                  && (state_q == S_WAIT) && (&empty_v);
        asg_mp     = mp_q;
        asg_block  = blk_q;
    end

    // Grid bookkeeping, held request and placement registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            target_q  <= '0;
            issued_q  <= '0;
            rq_thr_q  <= '0;
            rq_rpt_q  <= '0;
            rq_smem_q <= '0;
            blk_q     <= '0;
            mp_q      <= '0;
            last_q    <= MP_W'(NUM_MP - 1);
        end else begin
            if (grid_start) begin
                armed_q  <= 1'b1;
                target_q <= grid_blocks;
                issued_q <= '0;
            end else if (accept) begin
                issued_q <= issued_q + BLK_W'(1);
            end
            if (accept) begin
                rq_thr_q  <= req_threads;
                rq_rpt_q  <= req_regs;
                rq_smem_q <= req_smem;
                blk_q     <= issued_q;
            end
            if (commit) begin
                mp_q   <= pick;
                last_q <= pick;
            end
        end
    end
endmodule

// File: rtl/block_dispatch_chk.sv
module block_dispatch_chk #(
    parameter int NUM_MP      = 4,
    parameter int MP_W        = 2,
    parameter int BLK_W       = 16,
    parameter int MAX_BLOCKS  = 8,
    parameter int MAX_WARPS   = 32,
    parameter int REG_BUDGET  = 16384,
    parameter int SMEM_BUDGET = 16384,
    parameter int OB_W        = 4,
    parameter int OW_W        = 6,
    parameter int OR_W        = 15,
    parameter int OS_W        = 15
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_ready,
    input logic                        asg_valid,
    input logic                        asg_ready,
    input logic [MP_W-1:0]             asg_mp,
    input logic [BLK_W-1:0]            asg_block,
    input logic                        launch_err,
    input logic                        grid_done,
    input logic                        cpl_valid,
    input logic [MP_W-1:0]             cpl_mp,
    input logic [NUM_MP-1:0][OB_W-1:0] occ_b,
    input logic [NUM_MP-1:0][OW_W-1:0] occ_w,
    input logic [NUM_MP-1:0][OR_W-1:0] occ_r,
    input logic [NUM_MP-1:0][OS_W-1:0] occ_s
);
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (asg_valid && !asg_ready) |=> (asg_valid && $stable(asg_mp) && $stable(asg_block))); // R11

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_err |=> !launch_err); // R6

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        grid_done |-> (!asg_valid && !req_ready && !launch_err)); // R10

    AST_MP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        asg_valid |-> (int'(asg_mp) < NUM_MP)); // R7

    AST_RELEASE_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (occ_b[cpl_mp] != '0)); // R9

    generate
        for (genvar g = 0; g < NUM_MP; g++) begin : g_cap
            AST_BLOCK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                int'(occ_b[g]) <= MAX_BLOCKS); // R3
            AST_WARP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                int'(occ_w[g]) <= MAX_WARPS); // R2
            AST_REG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                int'(occ_r[g]) <= REG_BUDGET); // R4
            AST_SMEM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                int'(occ_s[g]) <= SMEM_BUDGET); // R5
        end
    endgenerate
endmodule

bind block_dispatch block_dispatch_chk #(
    .NUM_MP(NUM_MP), .MP_W(MP_W), .BLK_W(BLK_W),
    .MAX_BLOCKS(MAX_BLOCKS), .MAX_WARPS(MAX_WARPS),
    .REG_BUDGET(REG_BUDGET), .SMEM_BUDGET(SMEM_BUDGET),
    .OB_W(OB_W), .OW_W(OW_W), .OR_W(OR_W), .OS_W(OS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .asg_valid(asg_valid),
    .asg_ready(asg_ready), .asg_mp(asg_mp), .asg_block(asg_block),
    .launch_err(launch_err), .grid_done(grid_done),
    .cpl_valid(cpl_valid), .cpl_mp(cpl_mp),
    .occ_b(occ_b), .occ_w(occ_w), .occ_r(occ_r), .occ_s(occ_s)
);

// File: tb/block_dispatch_test.sv
module block_dispatch_test;
    localparam int CLK_PERIOD = 10;
    localparam int NMP = 4;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        grid_start = 1'b0;
    logic [15:0] grid_blocks = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [9:0]  req_threads = '0;
    logic [7:0]  req_regs = '0;
    logic [15:0] req_smem = '0;
    logic        asg_valid;
    logic        asg_ready = 1'b1;
    logic [1:0]  asg_mp;
    logic [15:0] asg_block;
    logic        launch_err;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_mp = '0;
    logic [9:0]  cpl_threads = '0;
    logic [7:0]  cpl_regs = '0;
    logic [15:0] cpl_smem = '0;
    logic        grid_done;

    block_dispatch uut (
        .clk(clk), .rst_n(rst_n), .grid_start(grid_start), .grid_blocks(grid_blocks),
        .req_valid(req_valid), .req_ready(req_ready), .req_threads(req_threads),
        .req_regs(req_regs), .req_smem(req_smem), .asg_valid(asg_valid),
        .asg_ready(asg_ready), .asg_mp(asg_mp), .asg_block(asg_block),
        .launch_err(launch_err), .cpl_valid(cpl_valid), .cpl_mp(cpl_mp),
        .cpl_threads(cpl_threads), .cpl_regs(cpl_regs), .cpl_smem(cpl_smem),
        .grid_done(grid_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { int mp; int t; int r; int s; } res_t;
    res_t res_q[$];

    int m_st;                    // 0 wait, 1 scan, 2 grant, 3 reject
    int m_armed, m_target, m_issued, m_blk, m_mp, m_last;
    int m_t, m_r, m_s;
    int m_nb[NMP], m_nw[NMP], m_nr[NMP], m_ns[NMP];

    function automatic int warps_of(int t); return (t + 31) / 32; endfunction
    function automatic bit never_fits(int t, int r, int s);
        return (t == 0) || (t > 512) || (s > 16384) || (t * r > 16384);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_armed = 0; m_target = 0; m_issued = 0; m_blk = 0;
            m_mp = 0; m_last = NMP - 1; m_t = 0; m_r = 0; m_s = 0;
            for (int i = 0; i < NMP; i++) begin
                m_nb[i] = 0; m_nw[i] = 0; m_nr[i] = 0; m_ns[i] = 0;
            end
            res_q.delete();
        end else begin
            int win;
            win = -1;
            case (m_st)
                0: if (m_armed != 0 && m_issued < m_target && req_valid) begin
                       m_t = int'(req_threads); m_r = int'(req_regs); m_s = int'(req_smem);
                       m_blk = m_issued; m_issued++; m_st = 1;
                   end
                1: begin
                       if (never_fits(m_t, m_r, m_s)) m_st = 3;
                       else begin
                           for (int k = 0; k < NMP; k++) begin
                               int i;
                               i = (m_last + 1 + k) % NMP;
                               if (win < 0 && m_nb[i] + 1 <= 8 && m_nw[i] + warps_of(m_t) <= 32
                                   && m_nr[i] + m_t * m_r <= 16384 && m_ns[i] + m_s <= 16384)
                                   win = i;
                           end
                           if (win >= 0) begin
                               m_mp = win; m_last = win; m_st = 2;
                           end
                       end
                   end
                2: if (asg_ready) m_st = 0;
                default: m_st = 0;
            endcase
            if (cpl_valid) begin
                int c;
                c = int'(cpl_mp);
                m_nb[c] -= 1; m_nw[c] -= warps_of(int'(cpl_threads));
                m_nr[c] -= int'(cpl_threads) * int'(cpl_regs); m_ns[c] -= int'(cpl_smem);
            end
            if (win >= 0) begin
                res_t e;
                m_nb[win] += 1; m_nw[win] += warps_of(m_t);
                m_nr[win] += m_t * m_r; m_ns[win] += m_s;
                e.mp = win; e.t = m_t; e.r = m_r; e.s = m_s;
                res_q.push_back(e);
            end
            if (grid_start) begin
                m_armed = 1; m_target = int'(grid_blocks); m_issued = 0;
            end
        end
    end

    function automatic int exp_done();
        int idle;
        idle = 1;
        for (int i = 0; i < NMP; i++) if (m_nb[i] != 0) idle = 0;
        return (m_armed != 0 && m_issued == m_target && m_st == 0 && idle != 0) ? 1 : 0;
    endfunction

    // Every-cycle comparison, away from the active edge.
    bit run_cmp = 1'b0;
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            check("R8",  "req_ready", int'(req_ready),
                  (m_st == 0 && m_armed != 0 && m_issued < m_target) ? 1 : 0);
            check("R11", "asg_valid", int'(asg_valid), (m_st == 2) ? 1 : 0);
            if (m_st == 2) begin
                check("R7", "asg_mp", int'(asg_mp), m_mp);
                check("R8", "asg_block", int'(asg_block), m_blk);
            end
            check("R6",  "launch_err", int'(launch_err), (m_st == 3) ? 1 : 0);
            check("R10", "grid_done", int'(grid_done), exp_done());
        end
    end

    // Observed grants and errors at the ports.
    int g_cnt = 0;
    int e_cnt = 0;
    always @(posedge clk) begin
        if (rst_n && asg_valid && asg_ready) g_cnt++;
        if (rst_n && launch_err) e_cnt++;
    end

    // Completion stream and consumer back-pressure.
    bit cpl_en = 1'b0;
    bit rdy_rand = 1'b0;
    always @(negedge clk) begin
        asg_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
        if (cpl_en && res_q.size() > 0 && (($urandom % 3) == 0)) begin
            res_t e;
            e = res_q.pop_front();
            cpl_valid = 1'b1; cpl_mp = 2'(e.mp);
            cpl_threads = 10'(e.t); cpl_regs = 8'(e.r); cpl_smem = 16'(e.s);
        end else begin
            cpl_valid = 1'b0;
        end
    end

    task automatic start_grid(int n);
        @(negedge clk);
        grid_blocks = 16'(n); grid_start = 1'b1;
        @(negedge clk);
        grid_start = 1'b0;
    endtask

    task automatic send_blk(int t, int r, int s);
        req_threads = 10'(t); req_regs = 8'(r); req_smem = 16'(s); req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!grid_done) @(negedge clk);
    endtask

    // Fill until the head stalls, then drain through completions.
    task automatic fill_case(string req, int t, int r, int s, int expect_n);
        g_cnt = 0;
        cpl_en = 1'b0;
        start_grid(expect_n + 4);
        fork
            begin
                for (int i = 0; i < expect_n + 4; i++) send_blk(t, r, s);
            end
            begin
                repeat (300) @(negedge clk);
                check(req, "placements before stall", g_cnt, expect_n);
                check("R8", "req_ready while head stalled", int'(req_ready), 0);
                cpl_en = 1'b1;
            end
        join
        wait_done();
        check("R9", "all placed after release", g_cnt, expect_n + 4);
        cpl_en = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check("R1", "req_ready", int'(req_ready), 0);
        check("R1", "asg_valid", int'(asg_valid), 0);
        check("R1", "launch_err", int'(launch_err), 0);
        check("R1", "grid_done", int'(grid_done), 0);
        run_cmp = 1'b1;

        // R10: empty grid completes at once
        start_grid(0);
        check("R10", "empty grid done", int'(grid_done), 1);

        // R1: first placement goes to multiprocessor 0
        start_grid(1);
        req_threads = 10'd32; req_regs = 8'd1; req_smem = '0; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        check("R1", "first asg_mp", int'(asg_mp), 0);
        check("R1", "first asg_valid", int'(asg_valid), 1);
        cpl_en = 1'b1; wait_done(); cpl_en = 1'b0;

        // R3: tiny blocks, 8 per multiprocessor
        fill_case("R3", 32, 1, 0, 8 * NMP);
        // R2: 257 threads -> 9 warps, 3 per multiprocessor
        fill_case("R2", 257, 1, 0, 3 * NMP);
        // R4: 256 x 32 = 8192 entries, 2 per multiprocessor
        fill_case("R4", 256, 32, 0, 2 * NMP);
        // R5: 6000 bytes, 2 per multiprocessor
        fill_case("R5", 32, 1, 6000, 2 * NMP);

        // R6: impossible blocks mixed with good ones, consumer stalls
        g_cnt = 0; e_cnt = 0; cpl_en = 1'b1; rdy_rand = 1'b1;
        start_grid(7);
        send_blk(64, 8, 100);
        send_blk(513, 1, 0);
        send_blk(128, 4, 0);
        send_blk(0, 1, 0);
        send_blk(32, 1, 16385);
        send_blk(512, 33, 0);
        send_blk(512, 32, 16384);
        wait_done();
        check("R6", "error pulses", e_cnt, 4);
        check("R6", "placements with errors", g_cnt, 3);

        // R9: random grid, completions overlapping placements
        g_cnt = 0;
        start_grid(60);
        for (int i = 0; i < 60; i++) begin
            int t, r;
            t = 1 + int'($urandom % 512);
            r = 1 + int'($urandom % 32);
            if (t * r > 16384) r = 16384 / t;
            send_blk(t, r, int'($urandom % 8192));
        end
        wait_done();
        check("R9", "random grid placements", g_cnt, 60);
        cpl_en = 1'b0; rdy_rand = 1'b0;
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule